// File: doc/BRIEF.md
# General-Purpose Pin Port Register Bank

This block is the register file of a 16-pin general-purpose port, reached over a simple synchronous bus. It holds the pin data word, two interrupt mask words, and five per-pin configuration words: direction, polarity, edge select, both-edge select and input enable. The data word and each mask word sit in a group of four addresses. The first address writes the word directly. The other three change it atomically: one clears the bits that are 1 in the write data, one sets them, and one inverts them. Software can therefore change single pins without a read-modify-write sequence.

The bank drives each pin from its data bit when that pin is configured as an output. It raises a one-cycle change indication for every output pin whose driven value really moved. After any accepted write to a mask group it pulses a recompute request toward the interrupt logic. Pin sampling and interrupt detection sit in a neighbouring block, which reads the masks and configuration words from this block's outputs. Only 16-bit accesses are accepted. A bad width is reported before the address is checked. Unmapped or misaligned addresses are also rejected, and a rejected access changes no register.

Top module: `pinbank_regs`

## Requirements
- R1: After reset every register is zero: pin_oe, pin_out, out_chg, mask_a, mask_b and all configuration outputs read 0, and reads return 0.
- R2: Plain writes at byte offsets 0x00 (data), 0x10 (mask A), 0x20 (mask B), 0x30 (direction), 0x34 (polarity), 0x38 (edge), 0x3C (both-edge) and 0x40 (input enable) store the write data, which reads back unchanged.
- R3: A write to group base + 0x4 (clear alias) clears each base-register bit that is 1 in the write data and leaves the other bits unchanged.
- R4: A write to group base + 0x8 (set alias) ORs the write data into the base register.
- R5: A write to group base + 0xC (toggle alias) XORs the write data into the base register.
- R6: A read of any of the four addresses in a group returns that group's base register.
- R7: bus_size encodes 00 = 8-bit, 01 = 16-bit, 10/11 = 32-bit. An access with a size other than 01 is rejected with bus_err = 1 and bus_err_kind = 0 (size), whatever its address. No register changes and read data is 0.
- R8: A 16-bit access to an offset that is not a multiple of 4 or lies above 0x40 is rejected with bus_err = 1, bus_err_kind = 1 (unmapped) and no register change.
- R9: pin_oe equals the direction register. pin_out[i] equals data bit i where direction bit i is 1 and is 0 elsewhere.
- R10: out_chg pulses for one cycle, in the cycle after an accepted write to the data group or direction register, on exactly the pins that are outputs after the write and whose data bit changed. A write that changes no output data bit gives out_chg = 0.
- R11: mask_upd_a (mask_upd_b) pulses for one cycle after each accepted write to any mask A (mask B) address. Other writes raise neither.
- R12: bus_rdata, bus_err and bus_err_kind are registered. They are valid in the cycle after the strobe for one cycle, and bus_rdata is 0 in every other cycle.
- R13: mask_a, mask_b, cfg_polar, cfg_edge, cfg_both and cfg_inen continuously present the stored register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access size code (01 = 16-bit) |
| bus_rdata | output | 16 | Registered read data |
| bus_err | output | 1 | One-cycle error pulse for a rejected access |
| bus_err_kind | output | 1 | 0 = bad size, 1 = unmapped offset |
| pin_out | output | 16 | Driven pin values |
| pin_oe | output | 16 | Pin output enables |
| out_chg | output | 16 | One-cycle per-pin output change indication |
| mask_a | output | 16 | Interrupt mask A |
| mask_b | output | 16 | Interrupt mask B |
| mask_upd_a | output | 1 | Recompute request for interrupt A |
| mask_upd_b | output | 1 | Recompute request for interrupt B |
| cfg_polar | output | 16 | Polarity word |
| cfg_edge | output | 16 | Edge-select word |
| cfg_both | output | 16 | Both-edge word |
| cfg_inen | output | 16 | Input-enable word |

## Verification
The assertions check several properties on every cycle. A rejected write leaves the data, mask and pin state untouched. A set on the data word never drops a 1, and a clear never creates one. An error response carries zero read data. out_chg only names output pins whose driven value really moved, and the mask recompute pulses only follow a write and never coincide. The scoreboard scenarios show the exact arithmetic of each alias against the bench's own model, the readback of all four addresses in a group, the priority of a size error over an unmapped address, and the choice of pins an out_chg pulse names for given direction and data values.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  // Alias offset within a four-address group selects the operation.
  typedef enum logic [1:0] {
    OP_BASE = 2'd0,
    OP_CLR  = 2'd1,
    OP_SET  = 2'd2,
    OP_TGL  = 2'd3
  } alias_op_e;

  typedef enum logic {
    ERR_SIZE = 1'b0,
    ERR_MAP  = 1'b1
  } err_kind_e;

  localparam logic [1:0] SIZE_HALF = 2'b01;
endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
  import pinbank_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_SLOTS = 17
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              bad_size,
  output logic              bad_map,
  output logic [ADDR_W-3:0] slot
);
  localparam int SLOT_W = ADDR_W - 2;

  assign slot     = addr[ADDR_W-1:2];
  assign bad_size = (size != SIZE_HALF);
  assign bad_map  = (addr[1:0] != 2'b00) || (slot >= SLOT_W'(NUM_SLOTS));
endmodule

// File: rtl/pinbank_alias_reg.sv
module pinbank_alias_reg
  import pinbank_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  alias_op_e       op,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] q,
  output logic [PINS-1:0] nxt
);
  function automatic logic [PINS-1:0] apply_alias(alias_op_e o,
                                                  logic [PINS-1:0] b,
                                                  logic [PINS-1:0] w);
    case (o)
      OP_BASE: return w;
      OP_CLR:  return b & ~w;
      OP_SET:  return b | w;
      default: return b ^ w;
    endcase
  endfunction

  assign nxt = we ? apply_alias(op, q, wdata) : q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/pinbank_cfg_bank.sv
module pinbank_cfg_bank #(
  parameter int PINS = 16,
  parameter int NREG = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NREG-1:0]           we,
  input  logic [PINS-1:0]           wdata,
  output logic [NREG-1:0][PINS-1:0] q,
  output logic [NREG-1:0][PINS-1:0] nxt
);
  for (genvar c = 0; c < NREG; c++) begin : g_reg
    assign nxt[c] = we[c] ? wdata : q[c];
    always_ff @(posedge clk) begin
      if (!rst_n) q[c] <= '0;
      else        q[c] <= nxt[c];
    end
  end
endmodule

// File: rtl/pinbank_outdrv.sv
module pinbank_outdrv #(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic [PINS-1:0] data_q,
  input  logic [PINS-1:0] data_nxt,
  input  logic [PINS-1:0] dir_q,
  input  logic [PINS-1:0] dir_nxt,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic [PINS-1:0] out_chg
);
  // Pins that will be outputs and whose data bit moves.
  function automatic logic [PINS-1:0] out_delta(logic [PINS-1:0] dir_new,
                                                logic [PINS-1:0] d_old,
                                                logic [PINS-1:0] d_new);
    return dir_new & (d_old ^ d_new);
  endfunction

  assign pin_oe  = dir_q;
  assign pin_out = data_q & dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   out_chg <= '0;
    else if (upd) out_chg <= out_delta(dir_nxt, data_q, data_nxt);
    else          out_chg <= '0;
  end
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int PINS       = 16,
  parameter int ADDR_W     = 8,
  parameter int NUM_GROUPS = 3,
  parameter int NUM_CFG    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_size,
  output logic [PINS-1:0]   bus_rdata,
  output logic              bus_err,
  output logic              bus_err_kind,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   out_chg,
  output logic [PINS-1:0]   mask_a,
  output logic [PINS-1:0]   mask_b,
  output logic              mask_upd_a,
  output logic              mask_upd_b,
  output logic [PINS-1:0]   cfg_polar,
  output logic [PINS-1:0]   cfg_edge,
  output logic [PINS-1:0]   cfg_both,
  output logic [PINS-1:0]   cfg_inen
);
  localparam int SLOT_W      = ADDR_W - 2;
  localparam int ALIAS_SLOTS = 4 * NUM_GROUPS;
  localparam int NUM_SLOTS   = ALIAS_SLOTS + NUM_CFG;
  localparam int GRP_DATA    = 0;
  localparam int GRP_MASKA   = 1;
  localparam int GRP_MASKB   = 2;
  localparam int CFG_DIR     = 0;
  localparam int CFG_POLAR   = 1;
  localparam int CFG_EDGE    = 2;
  localparam int CFG_BOTH    = 3;
  localparam int CFG_INEN    = 4;

  // Decode
  logic              bad_size, bad_map;
  logic [SLOT_W-1:0] slot;

  pinbank_decode #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_dec (
    .addr(bus_addr), .size(bus_size),
    .bad_size(bad_size), .bad_map(bad_map), .slot(slot)
  );

  // Named events, visible to the checker
  logic acc_req, acc_bad, wr_hit, rd_hit;
  logic data_set_ev, data_clr_ev;
  assign acc_req = bus_wr | bus_rd;
  assign acc_bad = acc_req & (bad_size | bad_map);
  assign wr_hit  = bus_wr & ~bad_size & ~bad_map;
  assign rd_hit  = bus_rd & ~bad_size & ~bad_map;

  logic                      in_alias;
  logic [NUM_GROUPS-1:0]     alias_we;
  logic [NUM_CFG-1:0]        cfg_we;
  alias_op_e                 alias_op;

  assign in_alias = (slot < SLOT_W'(ALIAS_SLOTS));
  assign alias_op = alias_op_e'(slot[1:0]);

  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++)
      alias_we[g] = wr_hit && in_alias && (slot[SLOT_W-1:2] == (SLOT_W-2)'(g));
    for (int c = 0; c < NUM_CFG; c++)
      cfg_we[c] = wr_hit && (slot == SLOT_W'(ALIAS_SLOTS + c));
  end

  assign data_set_ev = alias_we[GRP_DATA] && (alias_op == OP_SET);
  assign data_clr_ev = alias_we[GRP_DATA] && (alias_op == OP_CLR);

  // Storage
  logic [NUM_GROUPS-1:0][PINS-1:0] grp_q, grp_nxt;
  logic [NUM_CFG-1:0][PINS-1:0]    cfg_q, cfg_nxt;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_alias
    pinbank_alias_reg #(.PINS(PINS)) u_reg (
      .clk(clk), .rst_n(rst_n), .we(alias_we[g]), .op(alias_op),
      .wdata(bus_wdata), .q(grp_q[g]), .nxt(grp_nxt[g])
    );
  end

  pinbank_cfg_bank #(.PINS(PINS), .NREG(NUM_CFG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(bus_wdata),
    .q(cfg_q), .nxt(cfg_nxt)
  );

  logic [PINS-1:0] data_q;
  assign data_q = grp_q[GRP_DATA];

  // Pin drive and change indication
  pinbank_outdrv #(.PINS(PINS)) u_out (
    .clk(clk), .rst_n(rst_n),
    .upd(alias_we[GRP_DATA] | cfg_we[CFG_DIR]),
    .data_q(grp_q[GRP_DATA]), .data_nxt(grp_nxt[GRP_DATA]),
    .dir_q(cfg_q[CFG_DIR]), .dir_nxt(cfg_nxt[CFG_DIR]),
    .pin_out(pin_out), .pin_oe(pin_oe), .out_chg(out_chg)
  );

  // Read mux: alias addresses read the base of their group
  logic [PINS-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NUM_GROUPS; g++)
      if (in_alias && (slot[SLOT_W-1:2] == (SLOT_W-2)'(g))) rd_mux = grp_q[g];
    for (int c = 0; c < NUM_CFG; c++)
      if (slot == SLOT_W'(ALIAS_SLOTS + c)) rd_mux = cfg_q[c];
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata    <= '0;
      bus_err      <= 1'b0;
      bus_err_kind <= 1'b0;
      mask_upd_a   <= 1'b0;
      mask_upd_b   <= 1'b0;
    end else begin
      bus_rdata    <= rd_hit ? rd_mux : '0;
      bus_err      <= acc_bad;
      bus_err_kind <= acc_bad & ~bad_size;
      mask_upd_a   <= alias_we[GRP_MASKA];
      mask_upd_b   <= alias_we[GRP_MASKB];
    end
  end

  assign mask_a    = grp_q[GRP_MASKA];
  assign mask_b    = grp_q[GRP_MASKB];
  assign cfg_polar = cfg_q[CFG_POLAR];
  assign cfg_edge  = cfg_q[CFG_EDGE];
  assign cfg_both  = cfg_q[CFG_BOTH];
  assign cfg_inen  = cfg_q[CFG_INEN];
endmodule

// File: rtl/pinbank_regs_chk.sv
module pinbank_regs_chk #(
  parameter int PINS = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic            bus_err,
  input logic [PINS-1:0] bus_rdata,
  input logic            acc_bad,
  input logic            data_set_ev,
  input logic            data_clr_ev,
  input logic [PINS-1:0] data_q,
  input logic [PINS-1:0] mask_a,
  input logic [PINS-1:0] mask_b,
  input logic [PINS-1:0] pin_oe,
  input logic [PINS-1:0] pin_out,
  input logic [PINS-1:0] out_chg,
  input logic            mask_upd_a,
  input logic            mask_upd_b
);
  // R7, R12: an error response carries no read data
  a_r7_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));

  // R8: a rejected write leaves every stored word alone
  a_r8_bad_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_bad && bus_wr) |=> ($stable(data_q) && $stable(mask_a) &&
                             $stable(mask_b) && $stable(pin_oe)));

  // R4: setting never clears a bit
  a_r4_set_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
    data_set_ev |=> ((data_q & $past(data_q)) == $past(data_q)));

  // R3: clearing never raises a bit
  a_r3_clr_no_new_ones: assert property (@(posedge clk) disable iff (!rst_n)
    data_clr_ev |=> ((data_q & ~$past(data_q)) == '0));

  // R10: change indication only on output pins
  a_r10_chg_outputs_only: assert property (@(posedge clk) disable iff (!rst_n)
    (out_chg & ~pin_oe) == '0);

  // R10: change indication only where the driven value moved
  a_r10_chg_real_change: assert property (@(posedge clk) disable iff (!rst_n)
    (out_chg != '0) |-> ((out_chg & ~(pin_out ^ $past(pin_out))) == '0));

  // R11: recompute requests follow a write and never coincide
  a_r11_upd_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_upd_a || mask_upd_b) |-> $past(bus_wr));

  a_r11_upd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mask_upd_a && mask_upd_b));
endmodule

bind pinbank_regs pinbank_regs_chk #(.PINS(PINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_err(bus_err),
  .bus_rdata(bus_rdata), .acc_bad(acc_bad), .data_set_ev(data_set_ev),
  .data_clr_ev(data_clr_ev), .data_q(data_q), .mask_a(mask_a),
  .mask_b(mask_b), .pin_oe(pin_oe), .pin_out(pin_out), .out_chg(out_chg),
  .mask_upd_a(mask_upd_a), .mask_upd_b(mask_upd_b)
);

// File: tb/pinbank_regs_tb.sv
`timescale 1ns/1ps
module pinbank_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_size = 2'b01;
  logic [15:0] bus_rdata, pin_out, pin_oe, out_chg, mask_a, mask_b;
  logic [15:0] cfg_polar, cfg_edge, cfg_both, cfg_inen;
  logic        bus_err, bus_err_kind, mask_upd_a, mask_upd_b;

  always #4 clk = ~clk;

  pinbank_regs dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] rd;
    logic        err;
    logic        kind;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [7:0] a, input logic [15:0] d,
                     input logic [1:0] sz, input logic [15:0] erd,
                     input logic eerr, input logic ekind, input string tag);
    exp_t e;
    e.rd = erd; e.err = eerr; e.kind = ekind; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = wr; bus_rd = !wr;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_size = 2'b01;
  endtask

  task automatic wr16(input logic [7:0] a, input logic [15:0] d, input string tag);
    acc(1'b1, a, d, 2'b01, 16'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic rd16(input logic [7:0] a, input logic [15:0] e, input string tag);
    acc(1'b0, a, 16'h0, 2'b01, e, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compares each response against the queued expectation
  logic resp_pend = 1'b0;
  always @(posedge clk) resp_pend <= bus_wr | bus_rd;

  always @(negedge clk) begin
    if (resp_pend && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(bus_rdata == e.rd, {e.tag, " rdata"}, bus_rdata, e.rd);
      chk(bus_err == e.err, {e.tag, " err"}, {15'h0, bus_err}, {15'h0, e.err});
      if (e.err) chk(bus_err_kind == e.kind, {e.tag, " err kind"},
                     {15'h0, bus_err_kind}, {15'h0, e.kind});
    end
  end

  // Bench model of the data word and direction
  logic [15:0] m_data = '0, m_dir = '0;

  task automatic data_op(input logic [7:0] a, input logic [15:0] d, input string tag);
    logic [15:0] nd;
    case (a)
      8'h00: nd = d;
      8'h04: nd = m_data & ~d;
      8'h08: nd = m_data | d;
      default: nd = m_data ^ d;
    endcase
    wr16(a, d, tag);
    chk(out_chg == (m_dir & (nd ^ m_data)), {tag, " R10 out_chg"}, out_chg, m_dir & (nd ^ m_data));
    m_data = nd;
    chk(pin_out == (m_data & m_dir), {tag, " R9 pin_out"}, pin_out, m_data & m_dir);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pin_oe == 0 && pin_out == 0, "R1 pins", pin_oe | pin_out, 16'h0);
    chk(mask_a == 0 && mask_b == 0 && cfg_inen == 0, "R1 masks", mask_a | mask_b | cfg_inen, 16'h0);
    rd16(8'h00, 16'h0, "R1 data read");
    rd16(8'h40, 16'h0, "R1 inen read");

    // R2, R9, R10: direction write changes no output data
    wr16(8'h30, 16'h00FF, "R2 dir write");
    m_dir = 16'h00FF;
    chk(pin_oe == 16'h00FF, "R9 pin_oe", pin_oe, 16'h00FF);
    chk(out_chg == 0, "R10 dir write no chg", out_chg, 16'h0);
    rd16(8'h30, 16'h00FF, "R2 dir readback");

    data_op(8'h00, 16'h0F0F, "R2 data write");
    data_op(8'h08, 16'h00F0, "R4 data set");
    data_op(8'h04, 16'h0F03, "R3 data clear");
    data_op(8'h0C, 16'hFF01, "R5 data toggle");
    data_op(8'h08, 16'h0004, "R10 set no change");
    chk(out_chg == 0, "R10 unchanged gives zero", out_chg, 16'h0);
    // R6 all four data addresses
    rd16(8'h00, 16'hFFFD, "R6 data base");
    rd16(8'h04, 16'hFFFD, "R6 data clr addr");
    rd16(8'h08, 16'hFFFD, "R6 data set addr");
    rd16(8'h0C, 16'hFFFD, "R6 data tgl addr");

    // Mask A group, R11
    wr16(8'h10, 16'h1234, "R2 mask A write");
    chk(mask_upd_a && !mask_upd_b, "R11 mask A pulse", {14'h0, mask_upd_b, mask_upd_a}, 16'h1);
    chk(out_chg == 0, "R10 mask write no chg", out_chg, 16'h0);
    @(negedge clk);
    chk(!mask_upd_a, "R11 pulse one cycle", {15'h0, mask_upd_a}, 16'h0);
    wr16(8'h14, 16'h0204, "R3 mask A clear");
    chk(mask_a == 16'h1030, "R3 mask A", mask_a, 16'h1030);
    wr16(8'h18, 16'h000F, "R4 mask A set");
    chk(mask_a == 16'h103F, "R4 mask A", mask_a, 16'h103F);
    chk(mask_upd_a, "R11 alias pulse", {15'h0, mask_upd_a}, 16'h1);
    wr16(8'h1C, 16'h1001, "R5 mask A toggle");
    chk(mask_a == 16'h003E, "R5 mask A", mask_a, 16'h003E);
    rd16(8'h18, 16'h003E, "R6 mask A set addr");

    // Mask B group
    wr16(8'h20, 16'hA5A5, "R2 mask B write");
    chk(mask_upd_b && !mask_upd_a, "R11 mask B pulse", {14'h0, mask_upd_b, mask_upd_a}, 16'h2);
    wr16(8'h2C, 16'hFFFF, "R5 mask B toggle");
    rd16(8'h24, 16'h5A5A, "R6 mask B clr addr");
    wr16(8'h24, 16'h000A, "R3 mask B clear");
    chk(mask_b == 16'h5A50, "R3 mask B", mask_b, 16'h5A50);

    // Configuration words, R13
    wr16(8'h34, 16'h1111, "R2 polar");
    wr16(8'h38, 16'h2222, "R2 edge");
    wr16(8'h3C, 16'h4444, "R2 both");
    wr16(8'h40, 16'h8888, "R2 inen");
    chk(!mask_upd_a && !mask_upd_b, "R11 no pulse on cfg", {14'h0, mask_upd_b, mask_upd_a}, 16'h0);
    chk(cfg_polar == 16'h1111 && cfg_edge == 16'h2222, "R13 polar/edge", cfg_polar ^ cfg_edge, 16'h3333);
    chk(cfg_both == 16'h4444 && cfg_inen == 16'h8888, "R13 both/inen", cfg_both ^ cfg_inen, 16'hCCCC);
    rd16(8'h38, 16'h2222, "R2 edge readback");

    // Errors, R7 and R8
    acc(1'b1, 8'h00, 16'h0000, 2'b10, 16'h0, 1'b1, 1'b0, "R7 wide write");
    chk(pin_out == (m_data & m_dir), "R7 no change", pin_out, m_data & m_dir);
    acc(1'b0, 8'h50, 16'h0, 2'b00, 16'h0, 1'b1, 1'b0, "R7 size before map");
    acc(1'b1, 8'h44, 16'hFFFF, 2'b01, 16'h0, 1'b1, 1'b1, "R8 past end");
    acc(1'b0, 8'h02, 16'h0, 2'b01, 16'h0, 1'b1, 1'b1, "R8 misaligned read");
    acc(1'b1, 8'h11, 16'hFFFF, 2'b01, 16'h0, 1'b1, 1'b1, "R8 misaligned write");
    chk(mask_a == 16'h003E, "R8 mask A kept", mask_a, 16'h003E);
    rd16(8'h00, 16'hFFFD, "R8 data kept");
    // R12: response is one cycle only
    @(negedge clk);
    chk(bus_rdata == 0 && !bus_err, "R12 idle", bus_rdata, 16'h0);

    // Direction flip: new outputs, no change pulse
    wr16(8'h30, 16'hFF00, "R9 dir flip");
    m_dir = 16'hFF00;
    chk(out_chg == 0, "R10 dir flip no chg", out_chg, 16'h0);
    chk(pin_out == 16'hFF00, "R9 new outputs", pin_out, 16'hFF00);
    data_op(8'h0C, 16'h0F0F, "R10 toggle mixed pins");

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", 16'(exp_q.size()), 16'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule